// File: doc/BRIEF.md
# Lane-Confined High-Half Interleave Unit

This block is a vector permute datapath. It takes two source vectors and builds each result from only the upper half of every 128-bit lane, alternating elements between the two sources. An element-size select chooses 8-, 16-, 32- or 64-bit elements. A length select chooses an active vector of 64, 128, 256 or 512 bits. A per-element writemask can either merge old destination data or zero the element. A broadcast option feeds one scalar in place of the whole second source. A hold flag keeps destination bits above 128 in the narrow legacy form. Combinations that make no sense are flagged, and the old destination passes through unchanged.

The permute, masking and fill logic is purely combinational. A single output register with a valid flag closes the path, so each accepted operation appears one cycle after it is presented. The output stage has two named states. `ST_IDLE` means no result is being presented. `ST_LOADED` means `out_valid` is high. The transition IDLE→LOADED is taken on `in_valid`. LOADED→LOADED is taken on a further `in_valid`, which accepts back-to-back operations. LOADED→IDLE is taken when `in_valid` is low. The result register keeps its last value while idle.

Encodings: `esize` 0/1/2/3 selects 8/16/32/64-bit elements. `vlen` 0/1/2/3 selects 64/128/256/512 active bits.

Top module: `uhi_top`

## Requirements
- R1: Within a 128-bit lane, result element 2k is element k of the upper 64 bits of `src_a`, and result element 2k+1 is element k of the upper 64 bits of `src_b`. The lower 64 bits of each source have no effect.
- R2: For `vlen` 2 and 3, every 128-bit lane is permuted on its own, and no element moves across a lane boundary.
- R3: With `vlen`=0, the low 64 bits are built from the upper 32 bits of each source in the same alternating pattern (result byte 0 = `src_a` byte 4, result byte 1 = `src_b` byte 4). Bits 511:64 keep `dst_old`.
- R4: The mask bit j governs element j of the chosen size, and bit 0 governs the element at the lowest bits. When `mask_en` is 0 or the mask bit is 1, the element takes the permuted value. Otherwise the element keeps `dst_old` when `zero_mode`=0, and becomes zero when `zero_mode`=1.
- R5: With `bcast_en`=1 and `esize`=2, every 32-bit element of the second source is replaced by `bcast_val[31:0]`. With `esize`=3, every 64-bit element is replaced by `bcast_val`. Broadcast with `esize` 0 or 1 is illegal.
- R6: With `vlen`=1 and `keep_upper`=1, bits 511:128 keep `dst_old`. With `vlen`≥1 and `keep_upper`=0, every bit above the active length is zero.
- R7: An operation is illegal if any of these holds: broadcast with `esize`<2; `vlen`=0 with `esize`=3; masking or broadcast with `vlen`=0 or `keep_upper`=1; `keep_upper`=1 with `vlen`≥2; an active length wider than the datapath. An illegal operation sets `out_err`=1 and outputs `dst_old` unchanged. A legal operation gives `out_err`=0.
- R8: With `src_b` all zeros, the result holds the upper elements of `src_a` zero-extended to twice their width.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid`=1, and `out_vec` holds the result of that operation. After a cycle without `in_valid`, `out_valid` is low and `out_vec` does not change.
- R10: After reset, `out_valid`, `out_err` and `out_vec` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation presented this cycle |
| esize | input | 2 | Element size code |
| vlen | input | 2 | Active vector length code |
| keep_upper | input | 1 | Hold destination bits above 128 (legacy form) |
| mask_en | input | 1 | Apply writemask |
| zero_mode | input | 1 | Masked-off elements zeroed (1) or merged (0) |
| bcast_en | input | 1 | Replace second source with broadcast scalar |
| bcast_val | input | 64 | Broadcast scalar |
| src_a | input | 512 | First source vector |
| src_b | input | 512 | Second source vector |
| dst_old | input | 512 | Previous destination contents |
| wmask | input | 64 | Per-element writemask |
| out_valid | output | 1 | Result valid |
| out_vec | output | 512 | Registered result |
| out_err | output | 1 | Illegal combination flag for the registered result |

## Verification
On every cycle the assertions check the valid timing of the output stage and the error rules: an illegal request returns the old destination with the flag set, and a legal request never raises the flag. They also check two outcomes that follow from the inputs alone: bits above the active length are zero when the upper bits are not held, and an all-clear mask in zeroing mode gives a zero vector. The element placement across lanes, the mask-to-element mapping for each size, the broadcast replication and the zero-extension use can only be shown by the bench's sweeps. Those sweeps compare every size, length, mask mode, broadcast and hold setting against an element-level model.

// File: rtl/uhi_pkg.sv
package uhi_pkg;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_LOADED = 1'b1
    } ostate_e;

    // Source byte index feeding result byte p for element-size log2 es (bytes).
    // narrow selects 64-bit lanes instead of 128-bit lanes.
    function automatic int shuf_src(int p, int es, bit narrow, int nbytes);
        int lb, base, off, e, bi, k, s;
        lb   = narrow ? 8 : 16;
        base = p - (p % lb);
        off  = p % lb;
        e    = off >> es;
        bi   = off - (e << es);
        k    = e >> 1;
        s    = base + (lb / 2) + (k << es) + bi;
        return (s < nbytes) ? s : p;
    endfunction

    function automatic bit shuf_from_b(int p, int es, bit narrow);
        int lb;
        lb = narrow ? 8 : 16;
        return (((p % lb) >> es) & 1) == 1;
    endfunction

endpackage

// File: rtl/uhi_bcast.sv
module uhi_bcast #(
    parameter int VBYTES = 64
) (
    input  logic [VBYTES*8-1:0] src_b,
    input  logic [63:0]         scalar,
    input  logic                en,
    input  logic                wide,
    output logic [VBYTES*8-1:0] b_eff
);
    localparam int NCHUNK = VBYTES / 4;

    for (genvar i = 0; i < NCHUNK; i++) begin : g_chunk
        localparam int HALF = i % 2;
        always_comb begin
            if (!en)
                b_eff[i*32 +: 32] = src_b[i*32 +: 32];
            else if (wide)
                b_eff[i*32 +: 32] = scalar[HALF*32 +: 32];
            else
                b_eff[i*32 +: 32] = scalar[31:0];
        end
    end
endmodule

// File: rtl/uhi_shuffle.sv
module uhi_shuffle
    import uhi_pkg::*;
#(
    parameter int VBYTES = 64
) (
    input  logic [VBYTES*8-1:0] src_a,
    input  logic [VBYTES*8-1:0] src_b,
    input  logic [1:0]          esize,
    input  logic                narrow,
    output logic [VBYTES*8-1:0] shuf
);
    logic [VBYTES-1:0][7:0] a_by;
    logic [VBYTES-1:0][7:0] b_by;
    logic [VBYTES-1:0][7:0] o_by;

    assign a_by = src_a;
    assign b_by = src_b;
    assign shuf = o_by;

    for (genvar p = 0; p < VBYTES; p++) begin : g_byte
        logic [7:0] cand [8];
        for (genvar es = 0; es < 4; es++) begin : g_es
            localparam int  SW = shuf_src(p, es, 1'b0, VBYTES);
            localparam bit  BW = shuf_from_b(p, es, 1'b0);
            localparam int  SN = shuf_src(p, es, 1'b1, VBYTES);
            localparam bit  BN = shuf_from_b(p, es, 1'b1);
            assign cand[es]     = BW ? b_by[SW] : a_by[SW];
            assign cand[4 + es] = BN ? b_by[SN] : a_by[SN];
        end
        assign o_by[p] = cand[{narrow, esize}];
    end
endmodule

// File: rtl/uhi_fill.sv
module uhi_fill #(
    parameter int VBYTES = 64
) (
    input  logic [VBYTES*8-1:0] shuf,
    input  logic [VBYTES*8-1:0] dst_old,
    input  logic [VBYTES-1:0]   wmask,
    input  logic                mask_en,
    input  logic                zero_mode,
    input  logic [1:0]          esize,
    input  logic [1:0]          vlen,
    input  logic                hold_high,
    input  logic                err,
    output logic [VBYTES*8-1:0] result
);
    for (genvar p = 0; p < VBYTES; p++) begin : g_byte
        localparam int P = p;
        logic mbit;
        logic active;
        always_comb begin
            unique case (esize)
                2'd0:    mbit = wmask[P];
                2'd1:    mbit = wmask[P >> 1];
                2'd2:    mbit = wmask[P >> 2];
                default: mbit = wmask[P >> 3];
            endcase
            active = (P / 8) < (32'd1 << vlen);
            if (err)
                result[p*8 +: 8] = dst_old[p*8 +: 8];
            else if (!active)
                result[p*8 +: 8] = hold_high ? dst_old[p*8 +: 8] : 8'h00;
            else if (!mask_en || mbit)
                result[p*8 +: 8] = shuf[p*8 +: 8];
            else
                result[p*8 +: 8] = zero_mode ? 8'h00 : dst_old[p*8 +: 8];
        end
    end
endmodule

// File: rtl/uhi_top.sv
module uhi_top
    import uhi_pkg::*;
#(
    parameter int VBITS = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       esize,
    input  logic [1:0]       vlen,
    input  logic             keep_upper,
    input  logic             mask_en,
    input  logic             zero_mode,
    input  logic             bcast_en,
    input  logic [63:0]      bcast_val,
    input  logic [VBITS-1:0] src_a,
    input  logic [VBITS-1:0] src_b,
    input  logic [VBITS-1:0] dst_old,
    input  logic [VBITS/8-1:0] wmask,
    output logic             out_valid,
    output logic [VBITS-1:0] out_vec,
    output logic             out_err
);
    localparam int VBYTES = VBITS / 8;

    ostate_e          state, nxt;
    logic             illegal;
    logic             too_long;
    logic             narrow;
    logic             hold_high;
    logic [VBITS-1:0] b_eff;
    logic [VBITS-1:0] shuf;
    logic [VBITS-1:0] result;

    assign narrow    = (vlen == 2'd0);
    assign hold_high = narrow || keep_upper;
    assign too_long  = (32'd8 << vlen) > VBYTES;

    always_comb begin
        illegal = 1'b0;
        if (bcast_en && (esize < 2'd2))             illegal = 1'b1;
        if (narrow && (esize == 2'd3))              illegal = 1'b1;
        if (hold_high && (mask_en || bcast_en))     illegal = 1'b1;
        if (keep_upper && (vlen > 2'd1))            illegal = 1'b1;
        if (too_long)                               illegal = 1'b1;
    end

    uhi_bcast #(.VBYTES(VBYTES)) u_bcast (
        .src_b  (src_b),
        .scalar (bcast_val),
        .en     (bcast_en),
        .wide   (esize == 2'd3),
        .b_eff  (b_eff)
    );

    uhi_shuffle #(.VBYTES(VBYTES)) u_shuffle (
        .src_a  (src_a),
        .src_b  (b_eff),
        .esize  (esize),
        .narrow (narrow),
        .shuf   (shuf)
    );

    uhi_fill #(.VBYTES(VBYTES)) u_fill (
        .shuf      (shuf),
        .dst_old   (dst_old),
        .wmask     (wmask),
        .mask_en   (mask_en),
        .zero_mode (zero_mode),
        .esize     (esize),
        .vlen      (vlen),
        .hold_high (hold_high),
        .err       (illegal),
        .result    (result)
    );

    // Output stage state machine
    always_comb begin
        unique case (state)
            ST_IDLE:   nxt = in_valid ? ST_LOADED : ST_IDLE;
            ST_LOADED: nxt = in_valid ? ST_LOADED : ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vec <= '0;
            out_err <= 1'b0;
        end else if (in_valid) begin
            out_vec <= result;
            out_err <= illegal;
        end
    end

    assign out_valid = (state == ST_LOADED);

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_vec))); // R9
    AST_ERR_KEEPS_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && illegal) |=> (out_err && out_vec == $past(dst_old))); // R7
    AST_ERR_ONLY_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !illegal) |=> !out_err); // R7
    AST_BCAST_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bcast_en && esize < 2'd2) |=> out_err); // R5
    AST_ZERO_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !illegal && !keep_upper && vlen != 2'd0)
        |=> ((out_vec >> (64 << $past(vlen))) == '0)); // R6
    AST_MASK_ALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !illegal && mask_en && zero_mode && wmask == '0)
        |=> (out_vec == '0)); // R4
endmodule

// File: tb/sim_uhi_top.sv
`timescale 1ns/1ps
module sim_uhi_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   esize = '0;
    logic [1:0]   vlen = '0;
    logic         keep_upper = 1'b0;
    logic         mask_en = 1'b0;
    logic         zero_mode = 1'b0;
    logic         bcast_en = 1'b0;
    logic [63:0]  bcast_val = '0;
    logic [511:0] src_a = '0;
    logic [511:0] src_b = '0;
    logic [511:0] dst_old = '0;
    logic [63:0]  wmask = '0;
    logic         out_valid;
    logic [511:0] out_vec;
    logic         out_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    uhi_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .esize(esize), .vlen(vlen),
        .keep_upper(keep_upper), .mask_en(mask_en), .zero_mode(zero_mode),
        .bcast_en(bcast_en), .bcast_val(bcast_val), .src_a(src_a), .src_b(src_b),
        .dst_old(dst_old), .wmask(wmask), .out_valid(out_valid), .out_vec(out_vec),
        .out_err(out_err)
    );

    task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [511:0] ref_model(
        input logic [1:0] es, input logic [1:0] vl, input logic ku, input logic me,
        input logic zm, input logic be, input logic [63:0] sc,
        input logic [511:0] a, input logic [511:0] b, input logic [511:0] d,
        input logic [63:0] m, output logic e);
        logic [511:0] bb, tmp, r;
        int ew, vbits, lw, nl, j;
        ew    = 8 << es;
        vbits = 64 << vl;
        lw    = (vl == 0) ? 64 : 128;
        nl    = vbits / lw;
        e = (be && es < 2) || (vl == 0 && es == 3) ||
            ((vl == 0 || ku) && (me || be)) || (ku && vl > 1);
        if (e) return d;
        for (int i = 0; i < 512; i++)
            bb[i] = be ? ((es == 3) ? sc[i % 64] : sc[i % 32]) : b[i];
        tmp = '0;
        for (int ln = 0; ln < nl; ln++)
            for (int k = 0; k < lw / 2 / ew; k++)
                for (int t = 0; t < ew; t++) begin
                    tmp[ln*lw + 2*k*ew + t]     = a[ln*lw + lw/2 + k*ew + t];
                    tmp[ln*lw + (2*k+1)*ew + t] = bb[ln*lw + lw/2 + k*ew + t];
                end
        for (int i = 0; i < 512; i++) begin
            if (i >= vbits) r[i] = (vl == 0 || ku) ? d[i] : 1'b0;
            else begin
                j = i / ew;
                if (!me || m[j]) r[i] = tmp[i];
                else             r[i] = zm ? 1'b0 : d[i];
            end
        end
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [511:0] exp, held;
        logic         exp_err;
        string        tag;

        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 valid", {511'b0, out_valid}, '0);
        chk("R10 err", {511'b0, out_err}, '0);
        chk("R10 vec", out_vec, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep all sizes, lengths, mask modes, broadcast and hold flag
        for (int es = 0; es < 4; es++)
        for (int vl = 0; vl < 4; vl++)
        for (int mm = 0; mm < 3; mm++)
        for (int be = 0; be < 2; be++)
        for (int ku = 0; ku < 2; ku++)
        for (int rep = 0; rep < 3; rep++) begin
            in_valid   = 1'b1;
            esize      = 2'(es);
            vlen       = 2'(vl);
            keep_upper = 1'(ku);
            mask_en    = (mm != 0);
            zero_mode  = (mm == 2);
            bcast_en   = 1'(be);
            bcast_val  = {$urandom, $urandom};
            src_a      = rnd512();
            src_b      = rnd512();
            dst_old    = rnd512();
            wmask      = (rep == 2) ? 64'h0 : {$urandom, $urandom};
            exp = ref_model(esize, vlen, keep_upper, mask_en, zero_mode, bcast_en,
                            bcast_val, src_a, src_b, dst_old, wmask, exp_err);
            if (exp_err)          tag = "R7";
            else if (vl == 0)     tag = "R3";
            else if (be != 0)     tag = "R5";
            else if (mm != 0)     tag = "R4";
            else if (vl >= 2)     tag = "R2";
            else                  tag = "R1";
            @(negedge clk);
            chk(tag, out_vec, exp);
            chk("R7 flag", {511'b0, out_err}, {511'b0, exp_err});
            chk("R9 valid", {511'b0, out_valid}, {511'b0, 1'b1});
            if (!exp_err && vl != 0)
                chk("R6 upper", out_vec >> (64 << vl), exp >> (64 << vl));
        end

        // R8: zero second source gives zero extension of upper words
        esize = 2'd1; vlen = 2'd1; keep_upper = 1'b0; mask_en = 1'b0;
        zero_mode = 1'b0; bcast_en = 1'b0;
        src_a = rnd512(); src_b = '0; dst_old = rnd512();
        exp = '0;
        for (int k = 0; k < 4; k++) exp[k*32 +: 32] = {16'h0, src_a[64 + k*16 +: 16]};
        @(negedge clk);
        chk("R8 zext", out_vec, exp);

        // R9: idle cycle drops valid, holds result
        held = out_vec;
        in_valid = 1'b0;
        src_a = rnd512();
        @(negedge clk);
        chk("R9 drop", {511'b0, out_valid}, '0);
        chk("R9 hold", out_vec, held);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule